// File: doc/BRIEF.md
# Preset Interval Counter with Capture Modes

This block is a 16-bit up-counter paired with one preset/capture register. It advances one step on each rate tick while it is running. It can measure one interval, repeat an interval, or run freely and snapshot its value when an external trigger arrives. The tick comes from a separate rate generator. Flag latching and interrupt logic sit outside the block and consume its one-cycle overflow pulse.

Software reaches both registers through a single data port. A write made while the counter is stopped seeds both the counter and the preset. A write made while it runs changes only the preset. Reads always return the preset/capture register. A small two-state controller holds the run state: `ST_IDLE` (stopped) and `ST_RUN` (counting). It has three transitions:
- `go_start`: from `ST_IDLE` to `ST_RUN` on a go write of 1.
- `go_stop`: from `ST_RUN` to `ST_IDLE` on a go write of 0.
- `oneshot_done`: from `ST_RUN` to `ST_IDLE` when the counter wraps in one-shot mode and no go write arrives in the same cycle.

Mode encoding on `mode_i`:
- 00: one-shot.
- 01: repeat.
- 10: capture.
- 11: capture-and-clear.

Top module: `interval_capture_counter`

## Requirements
- R1: After reset, `count_o` is 0, `bus_rdata_o` is 0, `running_o` is 0 and `ovf_o` is 0.
- R2: A go write (`go_wr_i`=1) sets the run state to `go_val_i` from the next cycle. The counter adds 1 on a cycle with `tick_i`=1 only while running, and holds otherwise unless R6 or R8 applies.
- R3: In mode 00, a tick that takes the counter from 0xFFFF to 0 raises overflow and stops the counter, leaving it at 0. A go write in the same cycle takes priority over the stop.
- R4: In mode 01, a tick at 0xFFFF raises overflow and loads the preset value (as it was before that edge) into the counter. The run state stays on.
- R5: In modes 10 and 11, `trig2_i`=1 copies the pre-edge count into the preset/capture register and raises overflow. In mode 10 a tick in the same cycle still advances the counter.
- R6: In mode 11, `trig2_i`=1 also sets the counter to 0. This wins over a same-cycle tick.
- R7: In modes 10 and 11, a tick at 0xFFFF wraps the counter to 0, raises overflow and keeps it running.
- R8: A bus write while stopped loads `bus_wdata_i` into both the counter and the preset register. This wins over the clear of R6.
- R9: A bus write while running loads only the preset register. The counter is not changed by the write.
- R10: `bus_rdata_o` always shows the preset/capture register. In modes 00 and 01, `trig2_i` changes neither register and raises no overflow.
- R11: When a bus write and a capture happen in the same cycle, the preset register takes the bus data and overflow is still raised.
- R12: `ovf_o` is a registered pulse. It is high for exactly the one cycle after each edge that sees a wrap or a capture, and low after any edge that sees neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Rate tick, one cycle per count step |
| mode_i | input | 2 | Counting mode (00 one-shot, 01 repeat, 10 capture, 11 capture-and-clear) |
| go_wr_i | input | 1 | Strobe that writes the run state |
| go_val_i | input | 1 | Run state value written by `go_wr_i` |
| trig2_i | input | 1 | Trigger-2 event strobe |
| bus_wr_i | input | 1 | Write strobe for the shared data port |
| bus_wdata_i | input | 16 | Write data for the shared data port |
| bus_rdata_o | output | 16 | Preset/capture register contents |
| count_o | output | 16 | Current counter value |
| running_o | output | 1 | Run state (1 in `ST_RUN`) |
| ovf_o | output | 1 | One-cycle overflow/capture event pulse |

## Verification
The hardest cases to reach are the collisions: a wrap in the same cycle as a trigger, a bus write or a go write, and a write meeting a capture. A wrap only happens after about 65,000 ticks unless the counter is seeded near the top. Directed steps therefore first seed 0xFFFE or 0xFFFF while the counter is stopped, then start it. The random phase draws half of its write data from the top sixteen values, so the counter keeps landing next to a wrap while triggers, go writes and mode changes arrive at random.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'b00,
        MODE_REPEAT  = 2'b01,
        MODE_CAPTURE = 2'b10,
        MODE_CAPCLR  = 2'b11
    } pic_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pic_state_e;

    function automatic logic mode_captures(pic_mode_e m);
        return (m == MODE_CAPTURE) || (m == MODE_CAPCLR);
    endfunction

endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go_wr_i,
    input  logic      go_val_i,
    input  pic_mode_e mode_i,
    input  logic      wrap_i,
    input  logic      capture_i,
    output logic      running_o,
    output logic      ovf_o
);

    pic_state_e state_q;
    pic_state_e state_d;
    logic       ovf_q;

    // Next-state selection: go_start, go_stop, oneshot_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_wr_i && go_val_i) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (go_wr_i && !go_val_i) begin
                    state_d = ST_IDLE;
                end else if (!go_wr_i && wrap_i && (mode_i == MODE_ONESHOT)) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: event pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= wrap_i | capture_i;
        end
    end

    assign running_o = (state_q == ST_RUN);
    assign ovf_o     = ovf_q;

    // R3: one-shot wrap with no go write ends the run
    assert_oneshot_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && wrap_i && !go_wr_i && mode_i == MODE_ONESHOT) |=> !running_o);

    // R4 / R7: other modes keep running through a wrap
    assert_keep_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && wrap_i && !go_wr_i && mode_i != MODE_ONESHOT) |=> running_o);

    // R12: pulse follows an event by one cycle
    assert_ovf_after_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i || capture_i) |=> ovf_o);

    assert_ovf_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wrap_i || capture_i) |=> !ovf_o);

    // R2: go write takes effect on the next cycle
    assert_go_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go_wr_i |=> (running_o == $past(go_val_i)));

endmodule

// File: rtl/pic_counter.sv
module pic_counter
    import pic_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running_i,
    input  logic             tick_i,
    input  pic_mode_e        mode_i,
    input  logic             trig_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic [WIDTH-1:0] preset_i,
    output logic [WIDTH-1:0] count_o,
    output logic             wrap_o
);

    localparam logic [WIDTH-1:0] CNT_TOP  = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] CNT_ZERO = '0;
    localparam logic [WIDTH-1:0] CNT_ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;
    logic             step;
    logic             stopped_load;
    logic             clear_req;

    assign step         = running_i && tick_i;
    assign stopped_load = load_i && !running_i;
    assign clear_req    = trig_i && (mode_i == MODE_CAPCLR);
    assign wrap_o       = step && (cnt_q == CNT_TOP);

    always_comb begin
        cnt_d = cnt_q;
        if (stopped_load) begin
            cnt_d = load_val_i;
        end else if (clear_req) begin
            cnt_d = CNT_ZERO;
        end else if (step) begin
            if (wrap_o && (mode_i == MODE_REPEAT)) begin
                cnt_d = preset_i;
            end else begin
                cnt_d = cnt_q + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_ZERO;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

    // R2: nothing moves the counter while stopped without a load or clear
    assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_i && !load_i && !clear_req) |=> (count_o == $past(count_o)));

    // R8: write while stopped seeds the counter
    assert_stopped_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !running_i) |=> (count_o == $past(load_val_i)));

    // R9: write while running does not touch the counter
    assert_running_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && running_i && !tick_i && !clear_req) |=> $stable(count_o));

    // R4: repeat mode reloads the preset at the wrap
    assert_repeat_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && mode_i == MODE_REPEAT) |=> (count_o == $past(preset_i)));

    // R6: capture-and-clear zeroes the counter
    assert_capclr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_req && !(load_i && !running_i)) |=> (count_o == CNT_ZERO));

endmodule

// File: rtl/pic_buffer.sv
module pic_buffer #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             capture_i,
    input  logic [WIDTH-1:0] count_i,
    output logic [WIDTH-1:0] buf_o
);

    logic [WIDTH-1:0] buf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (wr_i) begin
            buf_q <= wdata_i;
        end else if (capture_i) begin
            buf_q <= count_i;
        end
    end

    assign buf_o = buf_q;

    // R5: capture takes the pre-edge count
    assert_capture_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && !wr_i) |=> (buf_o == $past(count_i)));

    // R11: bus data wins over a same-cycle capture
    assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (buf_o == $past(wdata_i)));

    // R10: untouched register holds
    assert_buffer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !capture_i) |=> $stable(buf_o));

endmodule

// File: rtl/interval_capture_counter.sv
module interval_capture_counter
    import pic_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [1:0]       mode_i,
    input  logic             go_wr_i,
    input  logic             go_val_i,
    input  logic             trig2_i,
    input  logic             bus_wr_i,
    input  logic [WIDTH-1:0] bus_wdata_i,
    output logic [WIDTH-1:0] bus_rdata_o,
    output logic [WIDTH-1:0] count_o,
    output logic             running_o,
    output logic             ovf_o
);

    pic_mode_e        mode;
    logic             running;
    logic             wrap;
    logic             capture;
    logic [WIDTH-1:0] count;
    logic [WIDTH-1:0] preset;

    assign mode    = pic_mode_e'(mode_i);
    assign capture = trig2_i && mode_captures(mode);

    pic_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_wr_i   (go_wr_i),
        .go_val_i  (go_val_i),
        .mode_i    (mode),
        .wrap_i    (wrap),
        .capture_i (capture),
        .running_o (running),
        .ovf_o     (ovf_o)
    );

    pic_counter #(.WIDTH(WIDTH)) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .running_i  (running),
        .tick_i     (tick_i),
        .mode_i     (mode),
        .trig_i     (trig2_i),
        .load_i     (bus_wr_i),
        .load_val_i (bus_wdata_i),
        .preset_i   (preset),
        .count_o    (count),
        .wrap_o     (wrap)
    );

    pic_buffer #(.WIDTH(WIDTH)) i_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr_i),
        .wdata_i   (bus_wdata_i),
        .capture_i (capture),
        .count_i   (count),
        .buf_o     (preset)
    );

    assign bus_rdata_o = preset;
    assign count_o     = count;
    assign running_o   = running;

    // R10: trigger in the interval modes leaves the preset alone
    assert_trig_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig2_i && !mode_i[1] && !bus_wr_i) |=> $stable(bus_rdata_o));

endmodule

// File: tb/test_interval_capture_counter.sv
module test_interval_capture_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        go_wr = 1'b0;
    logic        go_val = 1'b0;
    logic        trig = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic [15:0] count;
    logic        running;
    logic        ovf;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] m_count = 16'h0;
    logic [15:0] m_buf   = 16'h0;
    logic        m_run   = 1'b0;
    logic        m_ovf   = 1'b0;

    always #4 clk = ~clk;

    interval_capture_counter i_interval_capture_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .mode_i      (mode),
        .go_wr_i     (go_wr),
        .go_val_i    (go_val),
        .trig2_i     (trig),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .count_o     (count),
        .running_o   (running),
        .ovf_o       (ovf)
    );

    // Reference functions built from the requirements
    function automatic logic f_wrap(logic run, logic t, logic [15:0] c);
        return run && t && (c == 16'hFFFF);
    endfunction

    function automatic logic [15:0] f_count(logic run, logic t, logic [1:0] md, logic tr,
                                            logic w, logic [15:0] d, logic [15:0] c,
                                            logic [15:0] b);
        if (w && !run) return d;                        // R8
        if (tr && md == 2'b11) return 16'h0;            // R6
        if (run && t) begin
            if (c == 16'hFFFF && md == 2'b01) return b; // R4
            return c + 16'h1;                           // R2, R3, R7
        end
        return c;
    endfunction

    function automatic logic [15:0] f_buf(logic [1:0] md, logic tr, logic w,
                                          logic [15:0] d, logic [15:0] c, logic [15:0] b);
        if (w) return d;                 // R9, R11
        if (tr && md[1]) return c;       // R5
        return b;                        // R10
    endfunction

    function automatic logic f_run(logic run, logic gw, logic gv, logic wrp, logic [1:0] md);
        if (gw) return gv;                       // R2
        if (wrp && md == 2'b00) return 1'b0;     // R3
        return run;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 16'h0; m_buf = 16'h0; m_run = 1'b0; m_ovf = 1'b0;
        end else begin
            logic        wrp;
            logic [15:0] nc;
            logic [15:0] nb;
            logic        nr;
            wrp = f_wrap(m_run, tick, m_count);
            nc  = f_count(m_run, tick, mode, trig, wr, wdata, m_count, m_buf);
            nb  = f_buf(mode, trig, wr, wdata, m_count, m_buf);
            nr  = f_run(m_run, go_wr, go_val, wrp, mode);
            m_ovf   = wrp || (trig && mode[1]);   // R12
            m_count = nc; m_buf = nb; m_run = nr;
        end
    end

    task automatic chk(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cmp_model();
        chk("R2", "count", count, m_count);
        chk("R10", "rdata", rdata, m_buf);
        chk("R3", "running", {15'h0, running}, {15'h0, m_run});
        chk("R12", "ovf", {15'h0, ovf}, {15'h0, m_ovf});
    endtask

    // Called at a falling edge; drives one cycle and samples at the next falling edge
    task automatic cyc(input logic t, input logic gw, input logic gv, input logic tr,
                       input logic w, input logic [15:0] d);
        tick = t; go_wr = gw; go_val = gv; trig = tr; wr = w; wdata = d;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; go_wr = 1'b0; go_val = 1'b0; trig = 1'b0; wr = 1'b0; wdata = 16'h0;
        cmp_model();
    endtask

    function automatic logic [15:0] rnd_data();
        if ($urandom % 2 == 0) return 16'hFFF0 | 16'($urandom % 16);
        return 16'($urandom);
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "count", count, 16'h0);
        chk("R1", "rdata", rdata, 16'h0);
        chk("R1", "running", {15'h0, running}, 16'h0);
        chk("R1", "ovf", {15'h0, ovf}, 16'h0);

        // R8 write while stopped
        cyc(0, 0, 0, 0, 1, 16'h1234);
        chk("R8", "count", count, 16'h1234);
        chk("R8", "rdata", rdata, 16'h1234);

        // R2 ticks ignored while stopped, then counting
        cyc(1, 0, 0, 0, 0, 16'h0);
        cyc(1, 0, 0, 0, 0, 16'h0);
        chk("R2", "count stopped", count, 16'h1234);
        cyc(0, 1, 1, 0, 0, 16'h0);
        chk("R2", "running", {15'h0, running}, 16'h1);
        cyc(1, 0, 0, 0, 0, 16'h0);
        cyc(1, 0, 0, 0, 0, 16'h0);
        cyc(1, 0, 0, 0, 0, 16'h0);
        cyc(0, 0, 0, 0, 0, 16'h0);
        chk("R2", "count running", count, 16'h1237);

        // R9 write while running
        cyc(0, 0, 0, 0, 1, 16'hAAAA);
        chk("R9", "rdata", rdata, 16'hAAAA);
        chk("R9", "count", count, 16'h1237);

        // R3 one-shot
        cyc(0, 1, 0, 0, 0, 16'h0);
        mode = 2'b00;
        cyc(0, 0, 0, 0, 1, 16'hFFFE);
        cyc(0, 1, 1, 0, 0, 16'h0);
        cyc(1, 0, 0, 0, 0, 16'h0);
        chk("R3", "count", count, 16'hFFFF);
        cyc(1, 0, 0, 0, 0, 16'h0);
        chk("R3", "count", count, 16'h0);
        chk("R3", "ovf", {15'h0, ovf}, 16'h1);
        chk("R3", "running", {15'h0, running}, 16'h0);
        cyc(1, 0, 0, 0, 0, 16'h0);
        chk("R12", "ovf drops", {15'h0, ovf}, 16'h0);
        chk("R3", "count held", count, 16'h0);

        // R4 repeat
        mode = 2'b01;
        cyc(0, 0, 0, 0, 1, 16'hFFFF);
        cyc(0, 1, 1, 0, 0, 16'h0);
        cyc(1, 0, 0, 0, 0, 16'h0);
        chk("R4", "count", count, 16'hFFFF);
        chk("R4", "ovf", {15'h0, ovf}, 16'h1);
        chk("R4", "running", {15'h0, running}, 16'h1);
        cyc(0, 0, 0, 0, 1, 16'h0005);
        cyc(1, 0, 0, 0, 0, 16'h0);
        chk("R4", "reload", count, 16'h0005);

        // R5 capture
        cyc(0, 1, 0, 0, 0, 16'h0);
        mode = 2'b10;
        cyc(0, 0, 0, 0, 1, 16'h0010);
        cyc(0, 1, 1, 0, 0, 16'h0);
        cyc(1, 0, 0, 0, 0, 16'h0);
        cyc(1, 0, 0, 0, 0, 16'h0);
        cyc(1, 0, 0, 1, 0, 16'h0);
        chk("R5", "rdata", rdata, 16'h0012);
        chk("R5", "count", count, 16'h0013);
        chk("R5", "ovf", {15'h0, ovf}, 16'h1);

        // R6 capture and clear
        mode = 2'b11;
        cyc(1, 0, 0, 0, 0, 16'h0);
        cyc(1, 0, 0, 1, 0, 16'h0);
        chk("R6", "rdata", rdata, 16'h0014);
        chk("R6", "count", count, 16'h0);

        // R7 free-running wrap
        cyc(0, 1, 0, 0, 0, 16'h0);
        mode = 2'b10;
        cyc(0, 0, 0, 0, 1, 16'hFFFF);
        cyc(0, 1, 1, 0, 0, 16'h0);
        cyc(1, 0, 0, 0, 0, 16'h0);
        chk("R7", "count", count, 16'h0);
        chk("R7", "ovf", {15'h0, ovf}, 16'h1);
        chk("R7", "running", {15'h0, running}, 16'h1);

        // R10 trigger ignored in one-shot mode
        mode = 2'b00;
        cyc(0, 0, 0, 1, 0, 16'h0);
        chk("R10", "rdata", rdata, 16'hFFFF);
        chk("R10", "ovf", {15'h0, ovf}, 16'h0);
        chk("R10", "count", count, 16'h0);

        // R11 write meets capture
        mode = 2'b10;
        cyc(0, 0, 0, 1, 1, 16'h4321);
        chk("R11", "rdata", rdata, 16'h4321);
        chk("R11", "ovf", {15'h0, ovf}, 16'h1);
        chk("R11", "count", count, 16'h0);

        // Random phase against the reference functions
        for (int i = 0; i < 4000; i++) begin
            mode = 2'($urandom);
            cyc(1'($urandom % 2), ($urandom % 16) == 0, ($urandom % 4) != 0,
                ($urandom % 10) == 0, ($urandom % 16) == 0, rnd_data());
        end

        finish_run();
    end

endmodule